// File: doc/BRIEF.md
# Ethernet receive address and length filter

This block sits on the byte stream of an incoming Ethernet frame and decides whether the frame is kept. It looks at the destination address, the frame length and a set of receive-control bits. It holds a 48-bit station address and a 64-entry multicast hash table, both loaded through a small 32-bit register port.

Once the sixth destination byte has arrived, the block reports the outcome of the address match. When the last byte arrives, it reports the final verdict together with the broadcast and multicast flags, a frame-too-long flag, and the frame length clipped to the active size limit. The receive path downstream uses these outputs to commit or discard the buffered payload.

Top module: `rx_frame_filter`

## Requirements
- R1: A frame can be accepted only when control bits 1 (receive DMA enable) and 3 (receive MAC enable) are both set; otherwise accept_o is 0.
- R2: A frame of fewer than 10 data bytes is always dropped. A frame of fewer than 64 data bytes is dropped unless control bit 12 (short-frame accept) is set.
- R3: With control bit 14 (receive everything) set, any destination passes the address test.
- R4: A broadcast destination (all 48 bits one) passes only when control bit 17 is set.
- R5: A multicast destination passes when control bit 16 is set. A destination is multicast when bit 0 of the first byte is one and the address is not broadcast.
- R6: Otherwise a multicast destination passes only when control bit 15 is set and the hash table bit selected by the index is one. The index is bits 31:26 of a reflected CRC-32 (polynomial 0xEDB88320, seed all ones, no final inversion, each byte LSB first) taken over the six destination bytes. The index selects bit index[4:0] of hash word index[5].
- R7: A unicast destination passes only when all six bytes equal the station address. The register codes on cfg_sel_i are 0 for the address high word (byte 0 in bits 15:8, byte 1 in bits 7:0), 1 for the address low word (bytes 2..5 from bits 31:24 down to 7:0), 2 for hash word 0 and 3 for hash word 1. A write takes effect on the next cycle.
- R8: The size limit is 1522 bytes, or 9220 when control bit 13 is set. The frame size is the data byte count plus 4. On every done_o pulse, len_o is the smaller of the frame size and the limit, and too_long_o is set when the frame size exceeds the limit.
- R9: bcast_o and mcast_o are set only with accept_o, according to the destination type. A unicast frame sets neither.
- R10: dst_valid_o pulses for one cycle in the cycle after the sixth byte, carrying the address test result on dst_pass_o. done_o pulses for one cycle in the cycle after the byte marked last. The other outputs are 0 outside these pulses.
- R11: While in reset, every output is 0 and all configuration registers clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | MAC receive-control word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte, destination first |
| rx_last_i | input | 1 | Marks the final data byte of a frame |
| dst_valid_o | output | 1 | Address decision pulse |
| dst_pass_o | output | 1 | Address test result |
| done_o | output | 1 | End-of-frame pulse |
| accept_o | output | 1 | Frame accepted |
| bcast_o | output | 1 | Accepted broadcast frame |
| mcast_o | output | 1 | Accepted multicast frame |
| too_long_o | output | 1 | Frame exceeded the size limit |
| len_o | output | LEN_W | Clipped frame size including 4 check bytes |

## Verification
The assertions assume that ctrl_i does not change while a frame is in flight or in the cycle that follows its last byte. They also assume that successive frames are separated, so that two address decisions never fall in adjacent cycles. The stimulus changes the control word and the configuration registers only between frames. It ends each frame with at least one idle cycle before the next frame starts, which covers both assumptions.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DST_BYTES = 6;
  localparam int unsigned DST_W     = 8 * DST_BYTES;
  localparam int unsigned HASH_W    = 6;
  localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;

  // control word bit positions
  localparam int unsigned C_RXDMA  = 1;
  localparam int unsigned C_RXMAC  = 3;
  localparam int unsigned C_RUNT   = 12;
  localparam int unsigned C_JUMBO  = 13;
  localparam int unsigned C_ALL    = 14;
  localparam int unsigned C_HASH   = 15;
  localparam int unsigned C_MALL   = 16;
  localparam int unsigned C_BCAST  = 17;

  typedef enum logic [1:0] {
    SEL_ADDR_HI = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_HASH_0  = 2'd2,
    SEL_HASH_1  = 2'd3
  } cfg_sel_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [DST_W-1:0]  station_o,
  output logic [63:0]       hash_o
);
  logic [15:0] addr_hi_q;
  logic [31:0] addr_lo_q, hash0_q, hash1_q;
  logic [15:0] unused_hi;

  assign unused_hi = wdata_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      hash0_q   <= '0;
      hash1_q   <= '0;
    end else if (we_i) begin
      case (cfg_sel_e'(sel_i))
        SEL_ADDR_HI: addr_hi_q <= wdata_i[15:0];
        SEL_ADDR_LO: addr_lo_q <= wdata_i;
        SEL_HASH_0:  hash0_q   <= wdata_i;
        SEL_HASH_1:  hash1_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  assign station_o = {addr_hi_q, addr_lo_q};
  assign hash_o    = {hash1_q, hash0_q};
endmodule

// File: rtl/rxf_hdr_track.sv
module rxf_hdr_track
  import rxf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              first_i,
  input  logic              in_hdr_i,
  output logic [DST_W-1:0]  dst_o,
  output logic [HASH_W-1:0] hash_idx_o
);
  logic [DST_W-9:0] dst_q;
  logic [31:0]      crc_q, crc_next;

  assign dst_o      = {dst_q, data_i};
  assign crc_next   = crc_step(first_i ? 32'hFFFF_FFFF : crc_q, data_i);
  assign hash_idx_o = crc_next[31:32-HASH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
      crc_q <= '1;
    end else if (valid_i && in_hdr_i) begin
      dst_q <= dst_o[DST_W-9:0];
      crc_q <= crc_next;
    end
  end
endmodule

// File: rtl/rxf_len_check.sv
module rxf_len_check #(
  parameter int unsigned LEN_W     = 14,
  parameter int unsigned STD_MAX   = 1518,
  parameter int unsigned JUMBO_MAX = 9216,
  parameter int unsigned CRC_BYTES = 4,
  parameter int unsigned MIN_ANY   = 10,
  parameter int unsigned MIN_STD   = 64
) (
  input  logic [LEN_W:0]   n_i,
  input  logic             jumbo_i,
  input  logic             runt_i,
  output logic             len_ok_o,
  output logic             too_long_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned TW        = LEN_W + 2;
  localparam int unsigned STD_LIM   = STD_MAX + CRC_BYTES;
  localparam int unsigned JUMBO_LIM = JUMBO_MAX + CRC_BYTES;

  logic [TW-1:0] total, lim;

  assign total      = TW'(n_i) + TW'(CRC_BYTES);
  assign lim        = jumbo_i ? TW'(JUMBO_LIM) : TW'(STD_LIM);
  assign too_long_o = total > lim;
  assign len_o      = too_long_o ? lim[LEN_W-1:0] : total[LEN_W-1:0];
  assign len_ok_o   = (n_i >= (LEN_W+1)'(MIN_ANY)) &&
                      (runt_i || n_i >= (LEN_W+1)'(MIN_STD));
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      ctrl_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  output logic             dst_valid_o,
  output logic             dst_pass_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             bcast_o,
  output logic             mcast_o,
  output logic             too_long_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;

  logic [DST_W-1:0]  station, dst;
  logic [63:0]       hash_tbl;
  logic [HASH_W-1:0] hash_idx;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W:0]    n_cur;
  logic              hdr_end, is_bcast, is_mcast, addr_pass;
  logic              pass_q, bcast_q, mcast_q;
  logic              len_ok, long_d, rx_en;
  logic [LEN_W-1:0]  len_d;
  logic              unused_ctrl;

  assign unused_ctrl = ^{ctrl_i[31:18], ctrl_i[11:4], ctrl_i[2], ctrl_i[0]};

  rxf_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .station_o(station), .hash_o(hash_tbl)
  );

  rxf_hdr_track u_hdr (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .data_i(rx_data_i),
    .first_i(cnt_q == '0),
    .in_hdr_i(cnt_q < LEN_W'(DST_BYTES)),
    .dst_o(dst), .hash_idx_o(hash_idx)
  );

  assign n_cur = {1'b0, cnt_q} + 1'b1;

  rxf_len_check #(.LEN_W(LEN_W)) u_len (
    .n_i(n_cur), .jumbo_i(ctrl_i[C_JUMBO]), .runt_i(ctrl_i[C_RUNT]),
    .len_ok_o(len_ok), .too_long_o(long_d), .len_o(len_d)
  );

  assign hdr_end  = rx_valid_i && cnt_q == LEN_W'(DST_BYTES - 1);
  assign is_bcast = &dst;
  assign is_mcast = dst[DST_W-8] && !is_bcast;
  assign rx_en    = ctrl_i[C_RXDMA] && ctrl_i[C_RXMAC];

  // priority: everything, broadcast, multicast (all / hash), unicast
  always_comb begin
    if (ctrl_i[C_ALL])  addr_pass = 1'b1;
    else if (is_bcast)  addr_pass = ctrl_i[C_BCAST];
    else if (is_mcast)  addr_pass = ctrl_i[C_MALL] || (ctrl_i[C_HASH] && hash_tbl[hash_idx]);
    else                addr_pass = (dst == station);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (rx_valid_i) begin
      if (rx_last_i)            cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q  <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (rx_valid_i && rx_last_i) begin
      pass_q  <= 1'b0;
      bcast_q <= 1'b0;
      mcast_q <= 1'b0;
    end else if (hdr_end) begin
      pass_q  <= addr_pass;
      bcast_q <= is_bcast;
      mcast_q <= is_mcast;
    end
  end

  logic acc_d;
  assign acc_d = rx_en && len_ok && pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_valid_o <= 1'b0;
      dst_pass_o  <= 1'b0;
      done_o      <= 1'b0;
      accept_o    <= 1'b0;
      bcast_o     <= 1'b0;
      mcast_o     <= 1'b0;
      too_long_o  <= 1'b0;
      len_o       <= '0;
    end else begin
      dst_valid_o <= hdr_end;
      dst_pass_o  <= hdr_end && addr_pass;
      done_o      <= 1'b0;
      accept_o    <= 1'b0;
      bcast_o     <= 1'b0;
      mcast_o     <= 1'b0;
      too_long_o  <= 1'b0;
      len_o       <= '0;
      if (rx_valid_i && rx_last_i) begin
        done_o     <= 1'b1;
        accept_o   <= acc_d;
        bcast_o    <= acc_d && bcast_q;
        mcast_o    <= acc_d && mcast_q;
        too_long_o <= long_d;
        len_o      <= len_d;
      end
    end
  end
endmodule

// File: rtl/rx_frame_filter_chk.sv
module rx_frame_filter_chk #(
  parameter int unsigned LEN_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      ctrl_i,
  input logic             dst_valid_o,
  input logic             dst_pass_o,
  input logic             done_o,
  input logic             accept_o,
  input logic             bcast_o,
  input logic             mcast_o,
  input logic             too_long_o,
  input logic [LEN_W-1:0] len_o
);
  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl_i[31:14], ctrl_i[11:4], ctrl_i[2], ctrl_i[0]};

  // R1
  en_needed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(ctrl_i[1] && ctrl_i[3]));

  // R2
  short_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !$past(ctrl_i[12])) |-> (len_o >= LEN_W'(68)));

  // R8
  len_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o <= ($past(ctrl_i[13]) ? LEN_W'(9220) : LEN_W'(1522))));

  // R8
  long_clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    too_long_o |-> (len_o == ($past(ctrl_i[13]) ? LEN_W'(9220) : LEN_W'(1522))));

  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({bcast_o, mcast_o}) <= 1);

  // R9
  flag_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcast_o || mcast_o) |-> accept_o);

  // R10
  acc_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || too_long_o) |-> done_o);

  // R10
  dst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o |=> !dst_valid_o);

  // R10
  dst_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_pass_o |-> dst_valid_o);
endmodule

bind rx_frame_filter rx_frame_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
  .dst_valid_o(dst_valid_o), .dst_pass_o(dst_pass_o), .done_o(done_o),
  .accept_o(accept_o), .bcast_o(bcast_o), .mcast_o(mcast_o),
  .too_long_o(too_long_o), .len_o(len_o)
);

// File: tb/tb_rx_frame_filter.sv
`timescale 1ns/1ps
module tb_rx_frame_filter;
  localparam int LEN_W = 14;
  localparam logic [31:0] BASE  = 32'h0000_000A;
  localparam logic [31:0] RUNT  = 32'h0000_1000;
  localparam logic [31:0] JUMBO = 32'h0000_2000;
  localparam logic [31:0] ALL   = 32'h0000_4000;
  localparam logic [31:0] HASH  = 32'h0000_8000;
  localparam logic [31:0] MALL  = 32'h0001_0000;
  localparam logic [31:0] BCST  = 32'h0002_0000;

  logic clk = 0, rst_ni = 0;
  logic [31:0] ctrl = '0;
  logic cfg_we = 0; logic [1:0] cfg_sel = '0; logic [31:0] cfg_wdata = '0;
  logic rx_valid = 0, rx_last = 0; logic [7:0] rx_data = '0;
  logic dst_valid, dst_pass, done, accept, bcast, mcast, too_long;
  logic [LEN_W-1:0] len;

  int checks = 0, fails = 0;
  logic [47:0] station_m = '0;
  logic [63:0] hash_m = '0;

  always #2 clk = ~clk;

  rx_frame_filter #(.LEN_W(LEN_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .dst_valid_o(dst_valid), .dst_pass_o(dst_pass), .done_o(done),
    .accept_o(accept), .bcast_o(bcast), .mcast_o(mcast),
    .too_long_o(too_long), .len_o(len)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] d);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] v = d[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ v[i];
        c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
      end
    end
    return c[31:26];
  endfunction

  // R3 R4 R5 R6 R7 address rules
  function automatic logic ref_pass(input logic [31:0] c, input logic [47:0] d);
    logic bc = (d == '1);
    logic mc = d[40] && !bc;
    if (c[14]) return 1'b1;
    if (bc) return c[17];
    if (mc) return c[16] || (c[15] && hash_m[ref_idx(d)]);
    return d == station_m;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      2'd0: station_m[47:32] = data[15:0];
      2'd1: station_m[31:0]  = data;
      2'd2: hash_m[31:0]     = data;
      2'd3: hash_m[63:32]    = data;
      default: ;
    endcase
  endtask

  task automatic send(input string tag, input logic [31:0] c, input logic [47:0] d, input int n);
    logic p, e_acc, e_long, bc, mc;
    int tot, lim, e_len;
    p   = ref_pass(c, d);
    bc  = (d == '1);
    mc  = d[40] && !bc;
    tot = n + 4;
    lim = c[13] ? 9220 : 1522;
    e_long = tot > lim;
    e_len  = e_long ? lim : tot;
    e_acc  = c[1] && c[3] && n >= 10 && (n >= 64 || c[12]) && (n >= 6) && p;
    ctrl = c;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 6) check({tag, " R10 dst"}, {62'd0, dst_valid, dst_pass}, {62'd0, 1'b1, p});
      rx_valid = 1;
      rx_data  = (k < 6) ? d[47-8*k -: 8] : k[7:0];
      rx_last  = (k == n - 1);
    end
    @(negedge clk);
    if (n == 6) check({tag, " R10 dst"}, {62'd0, dst_valid, dst_pass}, {62'd0, 1'b1, p});
    rx_valid = 0; rx_last = 0;
    check({tag, " R8 R9 done"},
          {45'd0, done, accept, bcast, mcast, too_long, len},
          {45'd0, 1'b1, e_acc, e_acc && bc, e_acc && mc, e_long, e_len[LEN_W-1:0]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] st, md;
    logic [5:0] ix;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs", {55'd0, dst_valid, dst_pass, done, accept, bcast, mcast, too_long, 1'b0},
          64'd0);
    check("R11 reset len", {50'd0, len}, 64'd0);
    rst_ni = 1;
    // R11 registers cleared: all-zero unicast destination matches zero station
    send("R11 zero station", BASE, 48'h0, 64);

    wr(2'd0, 32'hFFFF_0211);
    wr(2'd1, 32'h2233_4455);
    st = 48'h0211_2233_4455;

    // R7 unicast match and per-byte mismatch
    send("R7 match", BASE, st, 64);
    for (int b = 0; b < 6; b++) send("R7 mismatch", BASE, st ^ (48'h04 << (8*b)), 64);

    // R1 enables
    send("R1 none", 32'h0, st, 64);
    send("R1 dma only", 32'h2, st, 64);
    send("R1 mac only", 32'h8, st, 64);

    // R4 broadcast
    send("R4 bcast off", BASE, '1, 64);
    send("R4 bcast on", BASE | BCST, '1, 64);
    send("R4 bcast unicast still", BASE | BCST, st, 70);

    // R3 receive everything, priority over disabled broadcast
    send("R3 all foreign", BASE | ALL, 48'h0A0B_0C0D_0E0F, 64);
    send("R3 all bcast", BASE | ALL, '1, 64);
    send("R3 all mcast", BASE | ALL, 48'h0100_5E00_0001, 64);

    // R5 R6 multicast and hash sweep
    for (int m = 0; m < 16; m++) begin
      md = {8'(8'h01 + 8'(m * 2)), 8'(m * 7), 32'h5E00_0000 | 32'(m)};
      ix = ref_idx(md);
      wr(2'd2, ix[5] ? 32'h0 : (32'h1 << ix[4:0]));
      wr(2'd3, ix[5] ? (32'h1 << ix[4:0]) : 32'h0);
      send("R6 hash hit", BASE | HASH, md, 64);
      send("R6 hash off", BASE, md, 64);
      wr(2'd2, ~hash_m[31:0]);
      wr(2'd3, ~hash_m[63:32]);
      send("R6 hash miss", BASE | HASH, md, 64);
      send("R5 mcast all", BASE | MALL, md, 64);
    end

    // R2 length thresholds
    for (int n = 1; n <= 70; n++) begin
      send("R2 len", BASE, st, n);
      send("R2 len runt", BASE | RUNT, st, n);
    end

    // R8 size limits
    for (int n = 1516; n <= 1520; n++) send("R8 std", BASE, st, n);
    send("R8 jumbo short", BASE | JUMBO, st, 1600);
    for (int n = 9215; n <= 9217; n++) send("R8 jumbo", BASE | JUMBO, st, n);
    send("R8 bcast long", BASE | BCST, '1, 1530);

    summary();
    $finish;
  end
endmodule